// File: doc/BRIEF.md
# Processor Reset Supervisor with Level-Change Watchdog

This block drives the reset line of a processor from three inputs: a digital supply-good flag, a watchdog kick from the processor, and a watchdog-off strap. The supply-good flag comes from an external threshold comparator and is assumed to be synchronous to `clk`. A low flag is a brown-out. It forces reset at once and holds it for as long as the flag stays low. Each time the flag is seen high again, and also after the block's own reset, the reset output is stretched by a fixed number of clock ticks before it releases.

The watchdog needs no register write. Any change of level on the kick input counts as a service. The kick input passes through a synchronizer before its edges are detected. If the kick input holds one level for the timeout interval, a reset pulse is generated. The timeout interval is counted only while reset is released. A processor that never kicks therefore sees reset pulses at a period of timeout plus pulse width. Both durations are given in clock ticks as parameters, and so is the polarity of the reset output.

Top module: `rst_supervisor`

## Requirements
- R1: After `rst_n` releases with `supply_ok` high, the reset output is asserted for exactly PULSE_TICKS clock cycles and then released.
- R2: While `supply_ok` is low, the reset output is asserted. This applies from the same cycle the flag falls, with no clock edge needed.
- R3: After `supply_ok` returns high, the reset output stays asserted for exactly PULSE_TICKS cycles, counted from the first cycle the flag is high.
- R4: If `wd_kick` holds a constant level (low or high) while reset is released, reset is asserted after exactly TIMEOUT_TICKS released cycles and lasts PULSE_TICKS cycles.
- R5: Any change of level on `wd_kick` restarts the timeout. Changes spaced fewer than TIMEOUT_TICKS cycles apart never cause a reset.
- R6: The timeout interval restarts only when a watchdog reset pulse has ended. The released window after each such pulse is a full TIMEOUT_TICKS cycles.
- R7: With `wd_kick` held constant, watchdog resets repeat with period TIMEOUT_TICKS + PULSE_TICKS (asserted PULSE_TICKS, released TIMEOUT_TICKS).
- R8: With ACTIVE_LOW = 1 an asserted reset drives `rst_out` to 0. With ACTIVE_LOW = 0 it drives `rst_out` to 1.
- R9: While `wd_off` is high the watchdog cannot trigger. After it drops, a held kick level causes a reset after exactly TIMEOUT_TICKS cycles.
- R10: The watchdog timer is held cleared while reset is asserted for any reason, including power-up and brown-out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's own state |
| supply_ok | input | 1 | Supply-good flag, synchronous to `clk`; low means brown-out |
| wd_kick | input | 1 | Watchdog service input, asynchronous; any level change services the watchdog |
| wd_off | input | 1 | Watchdog disable, high keeps the timer cleared |
| rst_out | output | 1 | Processor reset, polarity set by ACTIVE_LOW |

## Verification
The assertions assume two things about the inputs. First, `supply_ok` changes only between clock edges, so a brown-out is seen as an immediate level and not as a glitch. Second, `wd_off` is quasi-static. The bench changes every input just after a falling edge. It changes `wd_kick` level only at spacings far from the synchronizer depth, so each level change yields exactly one detected edge. Where the exact length of a released window is measured, the kick input is kept constant from well before the window opens. This keeps synchronizer latency out of the count.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

   // Width of a down/up counter able to hold the value n.
   function automatic int unsigned cnt_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

   typedef enum logic {
      POL_ACTIVE_HIGH = 1'b0,
      POL_ACTIVE_LOW  = 1'b1
   } rst_pol_e;

endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rsup_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_in};
   end

   assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/rsup_stretch.sv
module rsup_stretch
   import rsup_pkg::*;
#(
   parameter int unsigned PULSE_TICKS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_ok,
   input  logic wd_trip,
   output logic busy
);
   localparam int unsigned CW = cnt_w(PULSE_TICKS);
   localparam logic [CW-1:0] LOAD = CW'(PULSE_TICKS);

   generate
      if (PULSE_TICKS < 1) begin : g_bad_pulse
         $error("rsup_stretch: PULSE_TICKS must be at least 1");
      end
   endgenerate

   logic [CW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    left_q <= LOAD;
      else if (!supply_ok || wd_trip) left_q <= LOAD;
      else if (left_q != '0)         left_q <= left_q - 1'b1;
   end

   assign busy = (left_q != '0);

   AST_LOW_SUPPLY_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> (left_q == LOAD)); // R3
   AST_PULSE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      left_q <= LOAD); // R1
   AST_PULSE_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (supply_ok && !wd_trip && busy) |=> (left_q == $past(left_q) - 1'b1)); // R3
endmodule

// File: rtl/rsup_wdog.sv
module rsup_wdog
   import rsup_pkg::*;
#(
   parameter int unsigned TIMEOUT_TICKS = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick_s,
   input  logic hold,
   output logic kick_edge,
   output logic trip
);
   localparam int unsigned CW = cnt_w(TIMEOUT_TICKS);
   localparam logic [CW-1:0] LAST = CW'(TIMEOUT_TICKS - 1);

   generate
      if (TIMEOUT_TICKS < 2) begin : g_bad_timeout
         $error("rsup_wdog: TIMEOUT_TICKS must be at least 2");
      end
   endgenerate

   logic          prev_q;
   logic [CW-1:0] idle_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= kick_s;
   end

   assign kick_edge = kick_s ^ prev_q;
   assign trip      = !hold && !kick_edge && (idle_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        idle_q <= '0;
      else if (hold || kick_edge || trip) idle_q <= '0;
      else                               idle_q <= idle_q + 1'b1;
   end

   AST_IDLE_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      idle_q <= LAST); // R4
   AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (idle_q == '0)); // R10
   AST_KICK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      kick_edge |=> (idle_q == '0)); // R5
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
   import rsup_pkg::*;
#(
   parameter int unsigned PULSE_TICKS   = 40_000_000,
   parameter int unsigned TIMEOUT_TICKS = 320_000_000,
   parameter bit          ACTIVE_LOW    = 1'b1,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_ok,
   input  logic wd_kick,
   input  logic wd_off,
   output logic rst_out
);
   localparam rst_pol_e POL = ACTIVE_LOW ? POL_ACTIVE_LOW : POL_ACTIVE_HIGH;

   logic kick_s;
   logic kick_edge;
   logic wd_trip;
   logic pulse_busy;
   logic rst_active;
   logic wd_hold;

   rsup_sync #(.STAGES(SYNC_STAGES)) kick_sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (wd_kick),
      .q_out (kick_s)
   );

   rsup_stretch #(.PULSE_TICKS(PULSE_TICKS)) stretch_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .supply_ok (supply_ok),
      .wd_trip   (wd_trip),
      .busy      (pulse_busy)
   );

   assign rst_active = !supply_ok || pulse_busy;
   assign wd_hold    = wd_off || rst_active;

   rsup_wdog #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) wdog_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .kick_s    (kick_s),
      .hold      (wd_hold),
      .kick_edge (kick_edge),
      .trip      (wd_trip)
   );

   generate
      if (POL == POL_ACTIVE_LOW) begin : g_out_low
         assign rst_out = !rst_active;
      end else begin : g_out_high
         assign rst_out = rst_active;
      end
   endgenerate

   AST_TRIP_ONLY_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      wd_trip |-> !pulse_busy && supply_ok); // R6
   AST_OFF_NO_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
      wd_off |-> !wd_trip); // R9
   AST_EDGE_NO_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
      kick_edge |-> !wd_trip); // R5
   AST_TRIP_GIVES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      wd_trip |=> pulse_busy); // R4
endmodule

// File: tb/rst_supervisor_tb_top.sv
`timescale 1ns/1ps
module rst_supervisor_tb_top;
   localparam int unsigned P = 8;
   localparam int unsigned T = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic supply_ok = 1'b1;
   logic wd_kick = 1'b0;
   logic wd_off = 1'b0;
   logic rst_lo;
   logic rst_hi;
   int   checks = 0;
   int   errors = 0;

   always #2.5 clk = ~clk;

   rst_supervisor #(.PULSE_TICKS(P), .TIMEOUT_TICKS(T), .ACTIVE_LOW(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
      .wd_kick(wd_kick), .wd_off(wd_off), .rst_out(rst_lo));

   rst_supervisor #(.PULSE_TICKS(P), .TIMEOUT_TICKS(T), .ACTIVE_LOW(1'b0)) dut_hi_i (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
      .wd_kick(wd_kick), .wd_off(wd_off), .rst_out(rst_hi));

   function automatic logic act();
      return (rst_lo == 1'b0);
   endfunction

   task automatic chk(input string req, input int actual, input int expected);
      checks++;
      if (actual != expected) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
      end
   endtask

   // Counts consecutive falling-edge samples at the given reset level.
   task automatic run_len(input logic lvl, output int n);
      n = 0;
      while (act() == lvl && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic chk_polarity(input string tag);
      chk({"R8 ", tag, " low-polarity level"}, int'(rst_lo), int'(!act()));
      chk({"R8 ", tag, " high-polarity complement"}, int'(rst_hi), int'(!rst_lo));
   endtask

   task automatic t_power_up();
      int n;
      repeat (3) @(negedge clk);
      chk("R1 reset state", int'(act()), 1);
      rst_n = 1'b1;
      chk_polarity("asserted");
      run_len(1'b1, n);
      chk("R1 power-up pulse width", n, P);
      chk_polarity("released");
   endtask

   task automatic t_held_low();
      int n;
      run_len(1'b0, n);
      chk("R4 held-low released window", n, T);
      run_len(1'b1, n);
      chk("R4 watchdog pulse width", n, P);
      run_len(1'b0, n);
      chk("R6 window after watchdog pulse", n, T);
      run_len(1'b1, n);
      chk("R7 repeated pulse width", n, P);
   endtask

   task automatic t_service();
      int n;
      int bad = 0;
      run_len(1'b1, n);
      for (int i = 0; i < 12; i++) begin
         wd_kick = ~wd_kick;
         for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (act()) bad++;
         end
      end
      chk("R5 serviced kicks cause no reset", bad, 0);
   endtask

   task automatic t_disable();
      int n;
      int bad = 0;
      wd_off = 1'b1;
      for (int c = 0; c < 60; c++) begin
         @(negedge clk);
         if (act()) bad++;
      end
      chk("R9 disabled watchdog no reset", bad, 0);
      wd_off = 1'b0;
      run_len(1'b0, n);
      chk("R9 timeout after enable", n, T);
      run_len(1'b1, n);
      chk("R9 pulse after enable", n, P);
   endtask

   task automatic t_brown_out();
      int n;
      int bad = 0;
      supply_ok = 1'b0;
      #1;
      chk("R2 immediate assert on brown-out", int'(act()), 1);
      wd_kick = ~wd_kick;
      for (int c = 0; c < 30; c++) begin
         @(negedge clk);
         if (!act()) bad++;
      end
      chk("R2 held through brown-out", bad, 0);
      supply_ok = 1'b1;
      run_len(1'b1, n);
      chk("R3 pulse after supply returns", n, P);
      run_len(1'b0, n);
      chk("R10 full window after brown-out, held high (R4)", n, T);
      run_len(1'b1, n);
      chk("R4 held-high pulse width", n, P);
   endtask

   initial begin
      t_power_up();
      t_held_low();
      t_service();
      t_disable();
      t_brown_out();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule